// File: doc/BRIEF.md
# Timed-Access Write Guard

This block sits on a simple single-cycle register write bus (write enable, byte address, byte data) and holds a small bank of configuration registers. Some bits in these registers are critical. Each register has its own mask that marks these bits, and a plain bus write cannot change them. All other bits of the same registers update on every write, as normal.

Software changes a guarded bit in three steps. It writes 0xAA to the key address and then writes 0x55 to the same address. After that, it has three clock cycles in which to make one write to a guarded register. That write spends the window. A read-only flag shows when the window is open.

The default bank has four registers. The register at 0x91 guards bit 0 only. The register at 0x92 guards bits 5..0. The register at 0xA0 guards bits 7..4. The register at 0xB0 guards no bits. Register addresses, masks, reset values, the key address, the key bytes and the window length are all parameters.

Top module: `tap_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released, `win_open` is 0 and the registers hold their reset values: 0x00 at 0x91, 0x3F at 0x92, 0x50 at 0xA0 and 0x00 at 0xB0. `reg_q[8*i+7:8*i]` carries register i, where i counts 0x91, 0x92, 0xA0, 0xB0 in that order.
- R2: The key address is 0xC7. A write of 0xAA to it, followed by a write of 0x55 to it, completes the unlock sequence.
- R3: The sequence is cancelled by any write between 0xAA and 0x55, to any address. Cycles with no write (`bus_we` low) do not cancel it.
- R4: After an unlock, `win_open` is 1 for exactly three cycles, starting in the cycle after the 0x55 write. A guarded write in any of these three cycles takes effect. A guarded write in the fourth cycle does not.
- R5: A write to a register that has any guarded bit, made while the window is open, updates the guarded bits. It also closes the window from the next cycle on, whether or not any value changes.
- R6: While the window is closed, a write leaves the guarded bits unchanged, and the unguarded bits of the same register take the new data.
- R7: While the window is open, writes to a register with no guarded bits, or to an unmapped address, do not close the window. Writes to an unmapped address change no register.
- R8: A write of 0xAA to the key address always restarts detection, so 0xAA, 0xAA, 0x55 opens the window. A key write of any other value clears the detector, and so does a 0x55 write that does not follow 0xAA.
- R9: The guard masks are 0x01 at 0x91, 0x3F at 0x92, 0xF0 at 0xA0 and 0x00 at 0xB0.
- R10: A complete unlock while the window is already open reloads the full three-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| win_open | output | 1 | Guarded-write window is open |
| reg_q | output | 32 | Register bank contents, register i in bits 8*i+7..8*i |

## Verification
The assertions assume that the bus carries at most one write per cycle, that address and data are known whenever `bus_we` is high, and that the inputs change only away from the rising edge. The bench drives every input on the falling edge and holds `bus_we` low during reset. The stimulus interleaves key writes, idle gaps, guarded and unguarded writes, and unmapped writes. Because of this, each property is exercised both inside and outside the window.

// File: rtl/tap_pkg.sv
package tap_pkg;
   localparam int unsigned BUS_W = 8;
   localparam logic [BUS_W-1:0] DEF_KEY_ADDR   = 8'hC7;
   localparam logic [BUS_W-1:0] DEF_KEY_FIRST  = 8'hAA;
   localparam logic [BUS_W-1:0] DEF_KEY_SECOND = 8'h55;

   // merge new data into a register value under a guard mask
   function automatic logic [BUS_W-1:0] merge_bits(
      input logic [BUS_W-1:0] cur,
      input logic [BUS_W-1:0] nxt,
      input logic [BUS_W-1:0] guard,
      input logic             allow);
      logic [BUS_W-1:0] g_src;
      g_src = allow ? nxt : cur;
      return (nxt & ~guard) | (g_src & guard);
   endfunction
endpackage

// File: rtl/tap_key_detect.sv
module tap_key_detect #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hC7,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              unlock_o
);
   logic armed_q;
   logic is_key;
   logic got_first;

   if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
      $error("tap_key_detect: key bytes must differ");
   end

   assign is_key    = we_i && (addr_i == KEY_ADDR);
   assign got_first = is_key && (wdata_i == KEY_FIRST);
   assign unlock_o  = is_key && (wdata_i == KEY_SECOND) && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (we_i) begin
         armed_q <= got_first;
      end
   end
endmodule

// File: rtl/tap_window_timer.sv
module tap_window_timer #(
   parameter int unsigned WIN_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic unlock_i,
   input  logic consume_i,
   output logic open_o
);
   localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("tap_window_timer: window must last at least one cycle");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (unlock_i) begin
         cnt_q <= CNT_LOAD;
      end else if (consume_i) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign open_o = (cnt_q != '0);
endmodule

// File: rtl/tap_reg_bank.sv
module tap_reg_bank #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 4,
   parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDR  = {8'hB0, 8'hA0, 8'h92, 8'h91},
   parameter logic [NUM_REGS*DATA_W-1:0] GUARD_MSK = {8'h00, 8'hF0, 8'h3F, 8'h01},
   parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL   = {8'h00, 8'h50, 8'h3F, 8'h00}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic                       allow_i,
   output logic                       consume_o,
   output logic [NUM_REGS*DATA_W-1:0] q_o
);
   logic [NUM_REGS-1:0] guard_hit;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = REG_ADDR[g*ADDR_W +: ADDR_W];
      localparam logic [DATA_W-1:0] MY_MSK  = GUARD_MSK[g*DATA_W +: DATA_W];
      localparam logic [DATA_W-1:0] MY_RST  = RST_VAL[g*DATA_W +: DATA_W];
      logic              sel;
      logic [DATA_W-1:0] q;

      assign sel = we_i && (addr_i == MY_ADDR);

      if (MY_MSK == '0) begin : g_plain
         assign guard_hit[g] = 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= MY_RST;
            else if (sel) q <= wdata_i;
         end
      end else begin : g_guarded
         assign guard_hit[g] = sel;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= MY_RST;
            else if (sel) q <= tap_pkg::merge_bits(q, wdata_i, MY_MSK, allow_i);
         end
      end

      assign q_o[g*DATA_W +: DATA_W] = q;
   end

   assign consume_o = |guard_hit;
endmodule

// File: rtl/tap_guard.sv
module tap_guard #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned WIN_CYCLES = 3,
   parameter logic [ADDR_W-1:0] KEY_ADDR   = tap_pkg::DEF_KEY_ADDR,
   parameter logic [DATA_W-1:0] KEY_FIRST  = tap_pkg::DEF_KEY_FIRST,
   parameter logic [DATA_W-1:0] KEY_SECOND = tap_pkg::DEF_KEY_SECOND,
   parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDR  = {8'hB0, 8'hA0, 8'h92, 8'h91},
   parameter logic [NUM_REGS*DATA_W-1:0] GUARD_MSK = {8'h00, 8'hF0, 8'h3F, 8'h01},
   parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL   = {8'h00, 8'h50, 8'h3F, 8'h00}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic                       win_open,
   output logic [NUM_REGS*DATA_W-1:0] reg_q
);
   logic unlock;
   logic consume;

   if (DATA_W != tap_pkg::BUS_W) begin : g_bad_width
      $error("tap_guard: data width must match the package bus width");
   end
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_addr_chk
      if (REG_ADDR[g*ADDR_W +: ADDR_W] == KEY_ADDR) begin : g_clash
         $error("tap_guard: register address overlaps the key address");
      end
   end

   tap_key_detect #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
      .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) key_i (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .unlock_o(unlock)
   );

   tap_window_timer #(.WIN_CYCLES(WIN_CYCLES)) win_i (
      .clk(clk), .rst_n(rst_n), .unlock_i(unlock), .consume_i(consume),
      .open_o(win_open)
   );

   tap_reg_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
      .REG_ADDR(REG_ADDR), .GUARD_MSK(GUARD_MSK), .RST_VAL(RST_VAL)
   ) bank_i (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .allow_i(win_open), .consume_o(consume),
      .q_o(reg_q)
   );
endmodule

// File: rtl/tap_guard_chk.sv
module tap_guard_chk #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned WIN_CYCLES = 3,
   parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hC7,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
   parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDR  = {8'hB0, 8'hA0, 8'h92, 8'h91},
   parameter logic [NUM_REGS*DATA_W-1:0] GUARD_MSK = {8'h00, 8'hF0, 8'h3F, 8'h01},
   parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL   = {8'h00, 8'h50, 8'h3F, 8'h00}
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_we,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic                       win_open,
   input logic [NUM_REGS*DATA_W-1:0] reg_q
);
   localparam int unsigned AGE_W = $clog2(WIN_CYCLES + 2) + 1;

   logic             key_wr;
   logic             saw_first;
   logic             full_key;
   logic [AGE_W-1:0] age;

   assign key_wr   = bus_we && (bus_addr == KEY_ADDR);
   assign full_key = key_wr && (bus_wdata == KEY_SECOND) && saw_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saw_first <= 1'b0;
         age       <= '1;
      end else begin
         if (bus_we) saw_first <= key_wr && (bus_wdata == KEY_FIRST);
         if (full_key)                 age <= '0;
         else if (age != '1)           age <= age + 1'b1;
      end
   end

   AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      full_key |=> win_open); // R2

   AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(key_wr && bus_wdata == KEY_SECOND)); // R3

   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> (age < AGE_W'(WIN_CYCLES))); // R4

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg_chk
      localparam logic [ADDR_W-1:0] A = REG_ADDR[g*ADDR_W +: ADDR_W];
      localparam logic [DATA_W-1:0] M = GUARD_MSK[g*DATA_W +: DATA_W];
      if (M != '0) begin : g_guarded
         AST_SPEND_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
            (win_open && bus_we && bus_addr == A) |=> !win_open); // R5
         AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!win_open && bus_we && bus_addr == A)
            |=> $stable(reg_q[g*DATA_W +: DATA_W] & M)); // R6
      end
      AST_FREE_BITS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == A)
         |=> ((reg_q[g*DATA_W +: DATA_W] & ~M) == ($past(bus_wdata) & ~M))); // R6
   end
endmodule

bind tap_guard tap_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .WIN_CYCLES(WIN_CYCLES),
   .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
   .REG_ADDR(REG_ADDR), .GUARD_MSK(GUARD_MSK), .RST_VAL(RST_VAL)
) chk_i (.*);

// File: tb/tap_guard_tb_top.sv
module tap_guard_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        win_open;
   logic [31:0] reg_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_addr [NR] = '{8'h91, 8'h92, 8'hA0, 8'hB0};
   int m_msk  [NR] = '{8'h01, 8'h3F, 8'hF0, 8'h00};
   int m_rst  [NR] = '{8'h00, 8'h3F, 8'h50, 8'h00};
   int m_reg  [NR];
   int m_win;
   bit m_armed;

   always #(CLK_PERIOD/2) clk = ~clk;

   tap_guard dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .win_open(win_open), .reg_q(reg_q)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NR; i++) m_reg[i] = m_rst[i];
         m_win = 0;
         m_armed = 0;
      end else begin
         bit unl;
         bit spend;
         unl = 0;
         spend = 0;
         if (bus_we) begin
            if (bus_addr == 8'hC7) begin
               if (bus_wdata == 8'h55 && m_armed) unl = 1;
               m_armed = (bus_wdata == 8'hAA);
            end else begin
               m_armed = 0;
            end
            for (int i = 0; i < NR; i++) begin
               if (bus_addr == m_addr[i]) begin
                  int keep;
                  keep = (m_win > 0) ? 0 : m_msk[i];
                  m_reg[i] = (int'(bus_wdata) & ~keep & 255) | (m_reg[i] & keep);
                  if (m_msk[i] != 0) spend = 1;
               end
            end
         end
         if (unl) m_win = 3;
         else if (spend) m_win = 0;
         else if (m_win > 0) m_win = m_win - 1;
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R4 window model", int'(win_open), (m_win > 0) ? 1 : 0);
         for (int i = 0; i < NR; i++)
            check("R6 register model", int'(reg_q[i*8 +: 8]), m_reg[i]);
      end
   end

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         bus_we = 1'b0;
      end
   endtask

   task automatic unlock();
      wr(8'hC7, 8'hAA);
      wr(8'hC7, 8'h55);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 win_open in reset", int'(win_open), 0);
      rst_n = 1'b1;
      idle(1);
      check("R1 reset values", int'(reg_q), 32'h00503F00);

      // R6: locked writes keep guarded bits, free bits follow
      wr(8'h91, 8'hFF); idle(1);
      check("R6 0x91 locked", int'(reg_q[7:0]), 8'hFE);
      wr(8'h92, 8'h80); idle(1);
      check("R9 0x92 locked", int'(reg_q[15:8]), 8'hBF);
      wr(8'hA0, 8'h0F); idle(1);
      check("R9 0xA0 locked", int'(reg_q[23:16]), 8'h5F);

      // R2 R4: three-cycle window
      unlock(); idle(1);
      check("R2 open after key", int'(win_open), 1);
      idle(1); check("R4 open cycle 2", int'(win_open), 1);
      idle(1); check("R4 open cycle 3", int'(win_open), 1);
      idle(1); check("R4 closed cycle 4", int'(win_open), 0);

      // R5: guarded write spends the window
      unlock(); wr(8'h91, 8'h01); idle(1);
      check("R5 guarded write lands", int'(reg_q[7:0]), 8'h01);
      check("R5 window spent", int'(win_open), 0);

      // R3: intervening write cancels; idle gap does not
      wr(8'hC7, 8'hAA); wr(8'hB0, 8'h12); wr(8'hC7, 8'h55); idle(1);
      check("R3 cancelled by write", int'(win_open), 0);
      wr(8'hC7, 8'hAA); idle(2); wr(8'hC7, 8'h55); idle(1);
      check("R3 idle gap keeps arm", int'(win_open), 1);
      idle(3);

      // R8: rearm, clear, lone second key
      wr(8'hC7, 8'hAA); wr(8'hC7, 8'hAA); wr(8'hC7, 8'h55); idle(1);
      check("R8 double first key", int'(win_open), 1);
      idle(3);
      wr(8'hC7, 8'hAA); wr(8'hC7, 8'h12); wr(8'hC7, 8'h55); idle(1);
      check("R8 other key value clears", int'(win_open), 0);
      wr(8'hC7, 8'h55); idle(1);
      check("R8 lone second key", int'(win_open), 0);

      // R7: unguarded / unmapped writes keep window
      unlock(); wr(8'hB0, 8'h77); wr(8'h33, 8'hFF); idle(1);
      check("R7 window kept", int'(win_open), 1);
      check("R7 unguarded reg write", int'(reg_q[31:24]), 8'h77);
      idle(2);

      // R10: reload while open
      unlock(); idle(1); unlock(); idle(3);
      check("R10 reloaded window", int'(win_open), 1);
      idle(1);
      check("R10 reloaded window ends", int'(win_open), 0);

      // R4: last allowed cycle and first denied cycle
      unlock(); idle(2); wr(8'h92, 8'h00); idle(1);
      check("R4 write in cycle 3", int'(reg_q[15:8]), 8'h00);
      unlock(); idle(3); wr(8'h92, 8'h3F); idle(1);
      check("R4 write in cycle 4 denied", int'(reg_q[15:8]), 8'h00);

      idle(2);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule